// File: doc/BRIEF.md
# Interrupt Request and Enable Register Pair

This block holds the interrupt state of a contactless-reader front end. Six request flags latch events from the timer, the transmitter (frame sent), the receiver (frame received), the command engine (idle reached) and the FIFO level watch (high alert and low alert). A matching bank of six enable bits selects which of those flags may raise the interrupt line. The combined level is the OR of every flag that is both latched and enabled. It is presented as a status output and, through a small polarity and drive-mode stage, as the value and output-enable of the interrupt pin.

Neither register is written as a plain value. Bit 7 of every write is a selector. When it is 1, each 1 in bits 5..0 sets the matching bit. When it is 0, each 1 clears the matching bit. A 0 in bits 5..0 always leaves its bit alone. This lets software acknowledge or arm a single source without a read-modify-write. A hardware event always wins over a host clear that lands in the same cycle, so no event is lost.

The host bus decode and the event sources sit outside the block. The decode supplies one write strobe per register, and the sources supply single-cycle event pulses.

Top module: `irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the request and enable registers read 00h and the pin configuration reads 02h, which means push-pull and active-high. With that configuration the pin output is 0 and its output-enable is 1.
- R2: A request-register write with bit 7 = 1 sets every request bit whose data bit (5..0) is 1 and leaves the other request bits unchanged. Writing 81h sets only the low-alert flag.
- R3: A request-register write with bit 7 = 0 clears every request bit whose data bit is 1 and leaves the other request bits unchanged. Writing 3Fh clears all six flags.
- R4: The enable register changes only through a write to it, and that write uses the same bit-7 set/clear rule as R2 and R3.
- R5: An event pulse on a source input sets its request bit at the next clock edge. The bit then stays set until a host clear addresses it. The bit positions are: 0 low alert, 1 high alert, 2 idle, 3 receive done, 4 transmit done, 5 timer.
- R6: If an event and a host clear hit the same request bit in the same cycle, the bit ends up set.
- R7: The status level output equals the OR, over the six bit positions, of (request AND enable).
- R8: Reading either register returns bits 7 and 6 as 0.
- R9: Pin configuration bit 0 inverts the pin polarity. The pin value is the level XOR bit 0.
- R10: When pin configuration bit 1 is 1 (push-pull), the output-enable is 1 and the pin output carries the pin value. When bit 1 is 0 (open-drain), the pin output is 0 and the output-enable is 1 exactly when the pin value is 0.
- R11: A write to the pin configuration stores only bits 1..0. Bits 7..2 are ignored and read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Synchronous active-low reset |
| req_wr_i | input | 1 | Write strobe for the request register |
| en_wr_i | input | 1 | Write strobe for the enable register |
| cfg_wr_i | input | 1 | Write strobe for the pin configuration |
| wr_data_i | input | 8 | Write data; bit 7 selects set (1) or clear (0) for the flag registers |
| src_evt_i | input | 6 | Single-cycle event pulses, one per request source |
| req_rd_o | output | 8 | Request register read value |
| en_rd_o | output | 8 | Enable register read value |
| cfg_rd_o | output | 8 | Pin configuration read value |
| irq_level_o | output | 1 | Combined interrupt level (status) |
| irq_pin_o | output | 1 | Interrupt pin drive value |
| irq_pin_oe_o | output | 1 | Interrupt pin output-enable |

## Verification
Every register is visible on a read port one cycle after the edge that updates it. A wrong flag, enable or configuration bit therefore shows on the read ports in the cycle right after the faulty update, and on the level and pin outputs in that same cycle. The bench compares all read ports and pin outputs after each operation. This catches a lost set, a failed clear, a lost event in a set/clear collision, or a wrong polarity or drive mode within one cycle. The checker adds cycle-to-cycle properties on stickiness and on event priority.

// File: rtl/irq_ctrl_pkg.sv
// Package: shared encodings for the interrupt register pair.
// Assumes: six request sources at fixed bit positions; two-bit pin configuration.
package irq_ctrl_pkg;

    // Bit position of each request source within the flag registers.
    typedef enum int unsigned {
        SRC_LO_ALERT = 0,
        SRC_HI_ALERT = 1,
        SRC_IDLE     = 2,
        SRC_RX_DONE  = 3,
        SRC_TX_DONE  = 4,
        SRC_TIMER    = 5
    } irq_src_e;

    localparam int unsigned CFG_W = 2;

    // Pin stage configuration: bit 1 drive mode, bit 0 polarity invert.
    typedef struct packed {
        logic push_pull;
        logic invert;
    } pin_cfg_t;

endpackage

// File: rtl/irq_flag_bank.sv
// Module: irq_flag_bank
// A bank of SRC_N sticky flags written through a set/clear selector.
// When a write is selected, set_sel_i = 1 ORs mask_i into the flags and
// set_sel_i = 0 clears the masked flags. hw_set_i sets flags and wins over
// a clear in the same cycle. Assumes: synchronous active-low reset to zero.
module irq_flag_bank #(
    parameter int unsigned SRC_N = 6
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic             wr_i,
    input  logic             set_sel_i,
    input  logic [SRC_N-1:0] mask_i,
    input  logic [SRC_N-1:0] hw_set_i,
    output logic [SRC_N-1:0] flags_o
);

    logic [SRC_N-1:0] flag_q;

    for (genvar i = 0; i < SRC_N; i++) begin : g_bit
        logic host_set;
        logic host_clr;

        // Decode the host action for this bit.
        always_comb begin
            host_set = wr_i &&  set_sel_i && mask_i[i];
            host_clr = wr_i && !set_sel_i && mask_i[i];
        end

        // Flag register: hardware set has priority over host clear.
        always_ff @(posedge clk_i) begin
            if (!rst_n_i) begin
                flag_q[i] <= 1'b0;
            end else if (hw_set_i[i] || host_set) begin
                flag_q[i] <= 1'b1;
            end else if (host_clr) begin
                flag_q[i] <= 1'b0;
            end
        end
    end

    assign flags_o = flag_q;

endmodule

// File: rtl/irq_pin_drive.sv
// Module: irq_pin_drive
// Combines requests with enables into one level and shapes it for the pin.
// Polarity is optionally inverted; push-pull drives both levels, open-drain
// pulls low only. Assumes: inputs come straight from registers.
module irq_pin_drive
    import irq_ctrl_pkg::*;
#(
    parameter int unsigned SRC_N = 6
) (
    input  logic [SRC_N-1:0] req_i,
    input  logic [SRC_N-1:0] en_i,
    input  pin_cfg_t         cfg_i,
    output logic             level_o,
    output logic             pin_o,
    output logic             pin_oe_o
);

    logic pin_val;

    // Level, polarity and drive-mode shaping.
    always_comb begin
        level_o = |(req_i & en_i);
        pin_val = level_o ^ cfg_i.invert;
        if (cfg_i.push_pull) begin
            pin_o    = pin_val;
            pin_oe_o = 1'b1;
        end else begin
            pin_o    = 1'b0;
            pin_oe_o = !pin_val;
        end
    end

endmodule

// File: rtl/irq_ctrl.sv
// Module: irq_ctrl (top)
// Interrupt request and enable register pair with pin output stage.
// Assumes: one write strobe per register from an external bus decode;
// events are single-cycle pulses; bit DATA_W-1 of write data is the
// set/clear selector for both flag registers.
module irq_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned SRC_N     = 6,
    parameter logic [7:0]  CFG_RESET = 8'h02
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              req_wr_i,
    input  logic              en_wr_i,
    input  logic              cfg_wr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [SRC_N-1:0]  src_evt_i,
    output logic [DATA_W-1:0] req_rd_o,
    output logic [DATA_W-1:0] en_rd_o,
    output logic [DATA_W-1:0] cfg_rd_o,
    output logic              irq_level_o,
    output logic              irq_pin_o,
    output logic              irq_pin_oe_o
);

    localparam int unsigned SEL_BIT = DATA_W - 1;
    localparam int unsigned PAD_W   = DATA_W - SRC_N;
    localparam int unsigned CPAD_W  = DATA_W - CFG_W;

    logic [SRC_N-1:0] req_flags;
    logic [SRC_N-1:0] en_flags;
    pin_cfg_t         cfg_q;
    logic             unused_wr_bits;

    // Data bits between the flags and the selector carry no meaning.
    assign unused_wr_bits = ^wr_data_i[SEL_BIT-1:SRC_N];

    irq_flag_bank #(.SRC_N(SRC_N)) u_req_bank (
        .clk_i     (clk_i),
        .rst_n_i   (rst_n_i),
        .wr_i      (req_wr_i),
        .set_sel_i (wr_data_i[SEL_BIT]),
        .mask_i    (wr_data_i[SRC_N-1:0]),
        .hw_set_i  (src_evt_i),
        .flags_o   (req_flags)
    );

    irq_flag_bank #(.SRC_N(SRC_N)) u_en_bank (
        .clk_i     (clk_i),
        .rst_n_i   (rst_n_i),
        .wr_i      (en_wr_i),
        .set_sel_i (wr_data_i[SEL_BIT]),
        .mask_i    (wr_data_i[SRC_N-1:0]),
        .hw_set_i  ({SRC_N{1'b0}}),
        .flags_o   (en_flags)
    );

    // Pin configuration register: plain write of the low two bits.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            cfg_q <= pin_cfg_t'(CFG_RESET[CFG_W-1:0]);
        end else if (cfg_wr_i) begin
            cfg_q <= pin_cfg_t'(wr_data_i[CFG_W-1:0]);
        end
    end

    irq_pin_drive #(.SRC_N(SRC_N)) u_pin (
        .req_i    (req_flags),
        .en_i     (en_flags),
        .cfg_i    (cfg_q),
        .level_o  (irq_level_o),
        .pin_o    (irq_pin_o),
        .pin_oe_o (irq_pin_oe_o)
    );

    // Read values: unused upper bits return zero.
    assign req_rd_o = {{PAD_W{1'b0}}, req_flags};
    assign en_rd_o  = {{PAD_W{1'b0}}, en_flags};
    assign cfg_rd_o = {{CPAD_W{1'b0}}, cfg_q};

endmodule

// File: rtl/irq_ctrl_chk.sv
// Module: irq_ctrl_chk
// Property checker for irq_ctrl, attached by bind. Observes ports only.
module irq_ctrl_chk #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned SRC_N  = 6
) (
    input logic              clk_i,
    input logic              rst_n_i,
    input logic              req_wr_i,
    input logic              en_wr_i,
    input logic [DATA_W-1:0] wr_data_i,
    input logic [SRC_N-1:0]  src_evt_i,
    input logic [DATA_W-1:0] req_rd_o,
    input logic [DATA_W-1:0] en_rd_o,
    input logic [DATA_W-1:0] cfg_rd_o,
    input logic              irq_level_o,
    input logic              irq_pin_o,
    input logic              irq_pin_oe_o
);

    localparam int unsigned SEL_BIT = DATA_W - 1;

    // R2: masked bits are set after a set write.
    p_set_r2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (req_wr_i && wr_data_i[SEL_BIT]) |=>
        ((req_rd_o[SRC_N-1:0] & $past(wr_data_i[SRC_N-1:0])) == $past(wr_data_i[SRC_N-1:0])));

    // R3: masked bits without a concurrent event are clear after a clear write.
    p_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (req_wr_i && !wr_data_i[SEL_BIT]) |=>
        ((req_rd_o[SRC_N-1:0] & $past(wr_data_i[SRC_N-1:0] & ~src_evt_i)) == '0));

    // R4: enable register holds without a write to it.
    p_en_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !en_wr_i |=> $stable(en_rd_o));

    // R5: without a clear write, no set request bit falls.
    p_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !(req_wr_i && !wr_data_i[SEL_BIT]) |=>
        ((req_rd_o & $past(req_rd_o)) == $past(req_rd_o)));

    // R6: an event always leaves its bit set.
    p_evt_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (|src_evt_i) |=> ((req_rd_o[SRC_N-1:0] & $past(src_evt_i)) == $past(src_evt_i)));

    // R7: level matches the enabled requests seen on the read ports.
    p_level_r7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        irq_level_o == |(req_rd_o[SRC_N-1:0] & en_rd_o[SRC_N-1:0]));

    // R8: upper read bits are zero.
    p_rd_top_r8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (req_rd_o[DATA_W-1:SRC_N] == '0) && (en_rd_o[DATA_W-1:SRC_N] == '0));

    // R9: polarity in push-pull mode.
    p_polarity_r9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        cfg_rd_o[1] |-> (irq_pin_o == (irq_level_o ^ cfg_rd_o[0])));

    // R10: push-pull always drives; open-drain only pulls low.
    p_push_pull_r10: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        cfg_rd_o[1] |-> irq_pin_oe_o);
    p_open_drain_r10: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !cfg_rd_o[1] |-> (!irq_pin_o && (irq_pin_oe_o == !(irq_level_o ^ cfg_rd_o[0]))));

    // R11: configuration upper bits read as zero.
    p_cfg_top_r11: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        cfg_rd_o[DATA_W-1:2] == '0);

endmodule

bind irq_ctrl irq_ctrl_chk #(.DATA_W(DATA_W), .SRC_N(SRC_N)) chk_i (
    .clk_i        (clk_i),
    .rst_n_i      (rst_n_i),
    .req_wr_i     (req_wr_i),
    .en_wr_i      (en_wr_i),
    .wr_data_i    (wr_data_i),
    .src_evt_i    (src_evt_i),
    .req_rd_o     (req_rd_o),
    .en_rd_o      (en_rd_o),
    .cfg_rd_o     (cfg_rd_o),
    .irq_level_o  (irq_level_o),
    .irq_pin_o    (irq_pin_o),
    .irq_pin_oe_o (irq_pin_oe_o)
);

// File: tb/irq_ctrl_tb_top.sv
// Scoreboard bench: the driver applies one operation per step and pushes the
// expected port state from a requirement-level model; the monitor pops and
// compares at the following falling edge.
module irq_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_wr = 1'b0, en_wr = 1'b0, cfg_wr = 1'b0;
    logic [7:0] wr_data = '0;
    logic [5:0] evt = '0;
    logic [7:0] req_rd, en_rd, cfg_rd;
    logic       level, pin, pin_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        string      tag;
        logic [26:0] exp;
    } item_t;
    item_t sb_q[$];

    // Requirement-level model state.
    logic [5:0] m_req = '0, m_en = '0;
    logic [1:0] m_cfg = 2'b10;

    always #5 clk = ~clk;

    irq_ctrl dut_i (
        .clk_i(clk), .rst_n_i(rst_n), .req_wr_i(req_wr), .en_wr_i(en_wr),
        .cfg_wr_i(cfg_wr), .wr_data_i(wr_data), .src_evt_i(evt),
        .req_rd_o(req_rd), .en_rd_o(en_rd), .cfg_rd_o(cfg_rd),
        .irq_level_o(level), .irq_pin_o(pin), .irq_pin_oe_o(pin_oe)
    );

    function automatic logic [26:0] expect_now();
        logic lv, v, po, oe;
        lv = |(m_req & m_en);
        v  = lv ^ m_cfg[0];
        if (m_cfg[1]) begin po = v; oe = 1'b1; end
        else          begin po = 1'b0; oe = !v; end
        return {2'b00, m_req, 2'b00, m_en, 6'b0, m_cfg, lv, po, oe};
    endfunction

    task automatic push(string tag);
        item_t it;
        it.tag = tag;
        it.exp = expect_now();
        sb_q.push_back(it);
    endtask

    task automatic step(logic rq, logic en, logic cf, logic [7:0] d,
                        logic [5:0] ev, string tag);
        @(negedge clk);
        req_wr = rq; en_wr = en; cfg_wr = cf; wr_data = d; evt = ev;
        @(posedge clk);
        #1;
        if (rq) m_req = d[7] ? (m_req | d[5:0]) : (m_req & ~d[5:0]);
        m_req = m_req | ev;
        if (en) m_en = d[7] ? (m_en | d[5:0]) : (m_en & ~d[5:0]);
        if (cf) m_cfg = d[1:0];
        req_wr = 1'b0; en_wr = 1'b0; cfg_wr = 1'b0; wr_data = '0; evt = '0;
        push(tag);
    endtask

    // Monitor: compare one expected item per falling edge.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            logic [26:0] act;
            it  = sb_q.pop_front();
            act = {req_rd, en_rd, cfg_rd, level, pin, pin_oe};
            checks++;
            if (act !== it.exp) begin
                fails++;
                $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        push("R1 reset state");
        step(1, 0, 0, 8'h81, 6'h00, "R2 write 81h sets low alert only");
        step(1, 0, 0, 8'h86, 6'h00, "R2 set bits 1 and 2");
        step(1, 0, 0, 8'h02, 6'h00, "R3 clear bit 1 only");
        step(1, 0, 0, 8'h3F, 6'h00, "R3 write 3Fh clears all");
        step(0, 0, 0, 8'h00, 6'h10, "R5 transmit event sets bit 4");
        step(0, 0, 0, 8'h00, 6'h00, "R5 flag stays set");
        step(0, 1, 0, 8'h90, 6'h00, "R4 R7 enable bit 4 raises level");
        step(0, 1, 0, 8'h10, 6'h00, "R4 R7 clear enable drops level");
        step(1, 0, 0, 8'h80, 6'h00, "R2 set with empty mask changes nothing");
        step(0, 1, 0, 8'hBF, 6'h00, "R4 set all enables");
        step(1, 0, 0, 8'h10, 6'h10, "R6 event beats clear on bit 4");
        step(1, 0, 0, 8'h20, 6'h20, "R6 event beats clear on timer bit");
        step(0, 0, 1, 8'h03, 6'h00, "R9 push-pull inverted");
        step(0, 0, 1, 8'hFC, 6'h00, "R10 R11 open-drain, upper bits dropped");
        step(1, 0, 0, 8'h3F, 6'h00, "R10 open-drain idle pulls low");
        step(0, 0, 1, 8'h01, 6'h00, "R9 open-drain inverted released");
        step(1, 0, 0, 8'hFF, 6'h00, "R8 set all, bits 7..6 read zero");
        step(0, 1, 0, 8'h7F, 6'h00, "R4 R8 clear-all enables");
        step(0, 0, 1, 8'h02, 6'h00, "R10 back to push-pull");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule